// File: doc/BRIEF.md
# BCD Calendar Clock with Date-and-Time Alarm

This block keeps time of day and calendar date in packed BCD with 24-hour hours. It counts hundredths of a second, seconds, minutes, hours, a day of the week from 1 to 7, the day of the month, the month, a two-digit year, and a century bit above the year. An external divider, outside this block, derives a one-cycle strobe every hundredth of a second from a 32.768 kHz time base. Each strobe moves the count forward by one hundredth, and carries ripple upward through the fields in the same clock cycle.

Software reaches every field through a simple register port. Writes take effect at the next clock edge. Read data follows the address combinationally. The block also holds one alarm setting made of second, minute, hour, day of month and month, plus an arm bit. When a strobe carries the running time onto that setting, at hundredths 00, the block sets a sticky alarm flag and pulses a wake request for one cycle. The wake request can power up a sleeping system. No operating mode gates it, so it fires in normal and standby operation alike. Reading the flag register clears the flag.

Top module: `rtc_calendar`

## Requirements
- R1: After reset: time 00:00:00.00, day of week 1, date 01, month 01, year 00, century 0. All alarm fields and the arm bit are 0. alarm_flag and wake_req are low.
- R2: A clock cycle with tick_i low and no time write leaves every field unchanged. A cycle with tick_i high adds one to the hundredths in BCD, and hundredths roll from 99 to 00 with a carry into seconds.
- R3: Seconds and minutes roll from 59 to 00 and carry upward. Hours roll from 23 to 00 and carry into the date and the day of week.
- R4: The day of week counts 1 through 7, and 7 is followed by 1.
- R5: When the date is already at the last day of its month, the carry from hours resets it to 01 and carries into the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for every other month except February.
- R6: February ends at day 29 when the BCD year is a multiple of four, 00 included. Otherwise it ends at day 28.
- R7: Month rolls from 12 to 01 and carries into the year. Year rolls from 99 to 00 and inverts the century bit.
- R8: Register offsets and fields:
  - 0: reserved.
  - 1: seconds [6:0].
  - 2: minutes [6:0].
  - 3: hours [5:0].
  - 4: day of week [2:0].
  - 5: date [5:0].
  - 6: century in bit 7 and month in [4:0].
  - 7: year [7:0].
  - 8: hundredths [7:0].
  - 9 to 12: alarm second, minute, hour and date, in the same field widths as the time fields.
  - 13: arm bit in bit 7 and alarm month in [4:0].
  - 14: alarm flag in bit 7.
  - 15: spare.
  
  A write to any of offsets 1 to 8 loads at the next edge and cancels a tick in that same cycle. Unlisted bits read as 0.
- R9: When the arm bit is set and a tick moves the time to hundredths 00 with seconds, minutes, hours, date and month equal to the alarm fields, alarm_flag rises at that edge and wake_req is high for exactly that one cycle. A host write that puts the time on the alarm setting does not fire the alarm. Neither does a match while the arm bit is clear.
- R10: alarm_flag stays high until a cycle with rd_en high at offset 14, after which it is low. If an alarm fires in that same cycle, the flag stays high.
- R11: Offsets 0 and 15 always read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe, one per hundredth of a second |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (reading offset 14 clears the flag) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| alarm_flag | output | 1 | Sticky alarm flag |
| wake_req | output | 1 | One-cycle wake request on alarm match |

## Verification
A wrong count or carry is visible on rdata at the cycle after the faulty edge. The bench reads one register on every cycle and compares it with a behavioural calendar model. After each rollover it sweeps the whole register file, so a corrupted higher field is seen within sixteen cycles. A wrong alarm comparison shows on wake_req and alarm_flag at the very edge of the match. A lost or stuck flag shows on the next read of offset 14.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NFIELD = 7;   // hund, sec, min, hour, date, month, year

  typedef enum logic [ADDR_W-1:0] {
    A_RSVD  = 4'd0,  A_SEC   = 4'd1,  A_MIN   = 4'd2,  A_HOUR  = 4'd3,
    A_DOW   = 4'd4,  A_DATE  = 4'd5,  A_MON   = 4'd6,  A_YEAR  = 4'd7,
    A_HUND  = 4'd8,  A_ASEC  = 4'd9,  A_AMIN  = 4'd10, A_AHOUR = 4'd11,
    A_ADATE = 4'd12, A_AMON  = 4'd13, A_FLAG  = 4'd14, A_SPARE = 4'd15
  } reg_addr_e;

  typedef struct packed {
    logic       armed;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [5:0] date;
    logic [4:0] mon;
  } alarm_t;

  function automatic logic [DATA_W-1:0] bcd_inc(input logic [DATA_W-1:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [DATA_W-1:0] field_min(input int i);
    field_min = (i == 4 || i == 5) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [DATA_W-1:0] field_max(input int i);
    case (i)
      0:       field_max = 8'h99;
      1, 2:    field_max = 8'h59;
      3:       field_max = 8'h23;
      4:       field_max = 8'h31;
      5:       field_max = 8'h12;
      default: field_max = 8'h99;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] field_mask(input int i);
    case (i)
      1, 2:    field_mask = 8'h7F;
      3, 4:    field_mask = 8'h3F;
      5:       field_mask = 8'h1F;
      default: field_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] field_addr(input int i);
    case (i)
      0:       field_addr = 4'd8;
      1:       field_addr = 4'd1;
      2:       field_addr = 4'd2;
      3:       field_addr = 4'd3;
      4:       field_addr = 4'd5;
      5:       field_addr = 4'd6;
      default: field_addr = 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_cell.sv
module rtc_bcd_cell
  import rtc_cal_pkg::*;
#(
  parameter logic [DATA_W-1:0] MINV = '0,
  parameter logic [DATA_W-1:0] MASK = '1,
  parameter logic [DATA_W-1:0] RSTV = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_val,
  input  logic [DATA_W-1:0] lim,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] nxt,
  output logic              wrap
);
  assign wrap = step && (q == lim);

  always_comb begin
    nxt = q;
    if (load)      nxt = ld_val & MASK;
    else if (step) nxt = (q == lim) ? MINV : bcd_inc(q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             q <= RSTV;
    else if (load || step)  q <= nxt;
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  logic [DATA_W-1:0] mon,
  input  logic [DATA_W-1:0] yr,
  output logic [DATA_W-1:0] last_day
);
  logic leap;
  always_comb begin
    if (yr[4]) leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_cal_pkg::*;
(
  input  alarm_t            al,
  input  logic [DATA_W-1:0] hund,
  input  logic [DATA_W-1:0] sec,
  input  logic [DATA_W-1:0] min,
  input  logic [DATA_W-1:0] hour,
  input  logic [DATA_W-1:0] date,
  input  logic [DATA_W-1:0] mon,
  output logic              match
);
  assign match = al.armed && (hund == 8'h00) &&
                 (sec  == {1'b0, al.sec})  && (min  == {1'b0, al.min}) &&
                 (hour == {2'b0, al.hour}) && (date == {2'b0, al.date}) &&
                 (mon  == {3'b0, al.mon});
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              alarm_flag,
  output logic              wake_req
);
  logic              time_wr;
  logic [DATA_W-1:0] fq  [NFIELD];
  logic [DATA_W-1:0] fnx [NFIELD];
  logic [DATA_W-1:0] lim [NFIELD];
  logic [NFIELD:0]   cy;
  logic [DATA_W-1:0] mdays;
  logic [DATA_W-1:0] hund_q, sec_q;
  logic [2:0]        dow_q, dow_d;
  logic              cent_q, cent_d;
  alarm_t            al_q, al_d;
  logic              flag_q, flag_d, wake_q;
  logic              match, hit;

  assign time_wr = wr_en && (addr >= A_SEC) && (addr <= A_HUND);
  assign cy[0]   = tick_i && !time_wr;
  assign hund_q  = fq[0];
  assign sec_q   = fq[1];

  rtc_month_len u_mlen (.mon(fq[5]), .yr(fq[6]), .last_day(mdays));

  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
    if (gi == 4) begin : g_dyn
      assign lim[gi] = mdays;
    end else begin : g_fix
      assign lim[gi] = field_max(gi);
    end
    rtc_bcd_cell #(
      .MINV(field_min(gi)), .MASK(field_mask(gi)), .RSTV(field_min(gi))
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .step(cy[gi]),
      .load(wr_en && (addr == field_addr(gi))), .ld_val(wdata),
      .lim(lim[gi]), .q(fq[gi]), .nxt(fnx[gi]), .wrap(cy[gi+1])
    );
  end

  rtc_alarm_cmp u_cmp (
    .al(al_q), .hund(fnx[0]), .sec(fnx[1]), .min(fnx[2]), .hour(fnx[3]),
    .date(fnx[4]), .mon(fnx[5]), .match(match)
  );
  assign hit = cy[0] && match;

  always_comb begin
    dow_d  = dow_q;
    cent_d = cent_q;
    al_d   = al_q;
    if (wr_en && addr == A_DOW) dow_d = wdata[2:0];
    else if (cy[4])             dow_d = (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
    if (wr_en && addr == A_MON) cent_d = wdata[7];
    else if (cy[7])             cent_d = ~cent_q;
    if (wr_en) begin
      case (addr)
        A_ASEC:  al_d.sec  = wdata[6:0];
        A_AMIN:  al_d.min  = wdata[6:0];
        A_AHOUR: al_d.hour = wdata[5:0];
        A_ADATE: al_d.date = wdata[5:0];
        A_AMON:  begin al_d.mon = wdata[4:0]; al_d.armed = wdata[7]; end
        default: ;
      endcase
    end
    if (hit)                            flag_d = 1'b1;
    else if (rd_en && addr == A_FLAG)   flag_d = 1'b0;
    else                                flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q  <= 3'd1;
      cent_q <= 1'b0;
      al_q   <= '0;
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      dow_q  <= dow_d;
      cent_q <= cent_d;
      if (wr_en) al_q <= al_d;
      flag_q <= flag_d;
      wake_q <= hit;
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rdata = fq[1];
      A_MIN:   rdata = fq[2];
      A_HOUR:  rdata = fq[3];
      A_DOW:   rdata = {5'd0, dow_q};
      A_DATE:  rdata = fq[4];
      A_MON:   rdata = {cent_q, 2'b0, fq[5][4:0]};
      A_YEAR:  rdata = fq[6];
      A_HUND:  rdata = fq[0];
      A_ASEC:  rdata = {1'b0, al_q.sec};
      A_AMIN:  rdata = {1'b0, al_q.min};
      A_AHOUR: rdata = {2'b0, al_q.hour};
      A_ADATE: rdata = {2'b0, al_q.date};
      A_AMON:  rdata = {al_q.armed, 2'b0, al_q.mon};
      A_FLAG:  rdata = {flag_q, 7'd0};
      default: rdata = '0;
    endcase
  end

  assign alarm_flag = flag_q;
  assign wake_req   = wake_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              alarm_flag,
  input logic              wake_req,
  input logic [DATA_W-1:0] hund_q,
  input logic [DATA_W-1:0] sec_q
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en) |=> $stable(hund_q));

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_en && hund_q == 8'h99 && sec_q == 8'h59) |=> (sec_q == 8'h00));

  a_r8_write_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEC) |=> (sec_q == {1'b0, $past(wdata[6:0])}));

  a_r9_wake_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> alarm_flag);

  a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !(rd_en && addr == A_FLAG)) |=> alarm_flag);

  a_r10_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_FLAG) |=> (!alarm_flag || wake_req));

  a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_RSVD || addr == A_SPARE) |-> (rdata == 8'h00));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_flag(alarm_flag),
  .wake_req(wake_req), .hund_q(hund_q), .sec_q(sec_q)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alarm_flag, wake_req;

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural model state (plain integers)
  int m_h = 0, m_s = 0, m_mi = 0, m_hr = 0, m_dw = 1, m_dt = 1, m_mo = 1, m_yr = 0, m_c = 0;
  int a_s = 0, a_mi = 0, a_hr = 0, a_dt = 0, a_mo = 0, a_arm = 0;
  int m_flag = 0, m_wake = 0;

  always #10 clk = ~clk;

  rtc_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .alarm_flag(alarm_flag), .wake_req(wake_req)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim();
    if (m_mo == 2) return (m_yr % 4 == 0) ? 29 : 28;
    if (m_mo == 4 || m_mo == 6 || m_mo == 9 || m_mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd1:  return i2b(m_s);
      4'd2:  return i2b(m_mi);
      4'd3:  return i2b(m_hr);
      4'd4:  return 8'(m_dw);
      4'd5:  return i2b(m_dt);
      4'd6:  return 8'((m_c << 7) | m_mo % 10 | ((m_mo / 10) << 4));
      4'd7:  return i2b(m_yr);
      4'd8:  return i2b(m_h);
      4'd9:  return i2b(a_s);
      4'd10: return i2b(a_mi);
      4'd11: return i2b(a_hr);
      4'd12: return i2b(a_dt);
      4'd13: return 8'((a_arm << 7) | i2b(a_mo));
      4'd14: return 8'(m_flag << 7);
      default: return 8'h00;
    endcase
  endfunction

  task automatic advance();
    m_h++;
    if (m_h == 100) begin
      m_h = 0; m_s++;
      if (m_s == 60) begin
        m_s = 0; m_mi++;
        if (m_mi == 60) begin
          m_mi = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0;
            m_dw = (m_dw == 7) ? 1 : m_dw + 1;
            if (m_dt == dim()) begin
              m_dt = 1;
              if (m_mo == 12) begin
                m_mo = 1;
                if (m_yr == 99) begin m_yr = 0; m_c = 1 - m_c; end
                else m_yr++;
              end else m_mo++;
            end else m_dt++;
          end
        end
      end
    end
  endtask

  task automatic mdl(input bit tk, input bit we, input bit re, input logic [3:0] a, input logic [7:0] d);
    bit tw, hit;
    tw = we && (a >= 4'd1) && (a <= 4'd8);
    hit = 0;
    if (tw) begin
      case (a)
        4'd1: m_s  = b2i(d & 8'h7F);
        4'd2: m_mi = b2i(d & 8'h7F);
        4'd3: m_hr = b2i(d & 8'h3F);
        4'd4: m_dw = int'(d[2:0]);
        4'd5: m_dt = b2i(d & 8'h3F);
        4'd6: begin m_mo = b2i(d & 8'h1F); m_c = int'(d[7]); end
        4'd7: m_yr = b2i(d);
        default: m_h = b2i(d);
      endcase
    end else if (tk) begin
      advance();
      hit = (a_arm == 1) && m_h == 0 && m_s == a_s && m_mi == a_mi &&
            m_hr == a_hr && m_dt == a_dt && m_mo == a_mo;
    end
    if (we) begin
      case (a)
        4'd9:  a_s  = b2i(d & 8'h7F);
        4'd10: a_mi = b2i(d & 8'h7F);
        4'd11: a_hr = b2i(d & 8'h3F);
        4'd12: a_dt = b2i(d & 8'h3F);
        4'd13: begin a_mo = b2i(d & 8'h1F); a_arm = int'(d[7]); end
        default: ;
      endcase
    end
    if (hit) m_flag = 1;
    else if (re && a == 4'd14) m_flag = 0;
    m_wake = hit ? 1 : 0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit we, input bit re, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_i = tk; wr_en = we; rd_en = re; addr = a; wdata = d;
    #1;
    chk(rdata, exp_rd(a), $sformatf("rdata@%0d", a));
    chk({7'd0, alarm_flag}, 8'(m_flag), "alarm_flag");
    chk({7'd0, wake_req}, 8'(m_wake), "wake_req");
    @(posedge clk);
    mdl(tk, we, re, a, d);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(0, 1, 0, a, d);
  endtask

  task automatic ticks(input int n, input logic [3:0] a);
    for (int i = 0; i < n; i++) step(1, 0, 0, a, 8'h00);
  endtask

  task automatic scan();
    for (int i = 0; i < 16; i++) step(0, 0, 0, 4'(i), 8'h00);
  endtask

  task automatic set_time(input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] s,
                          input logic [7:0] h, input logic [7:0] dw, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
    wr(4'd3, hr); wr(4'd2, mi); wr(4'd1, s); wr(4'd8, h);
    wr(4'd4, dw); wr(4'd5, dt); wr(4'd6, mo); wr(4'd7, yr);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every register
    cur_req = "R1";
    scan();
    // R2: hundredths count and hold without tick
    cur_req = "R2";
    ticks(120, 4'd8);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 4'd8, 8'h00);
    step(0, 0, 0, 4'd1, 8'h00);
    // R3: second/minute/hour rollover into date and day
    cur_req = "R3";
    set_time(8'h12, 8'h34, 8'h59, 8'h99, 8'h03, 8'h10, 8'h05, 8'h30);
    ticks(1, 4'd2); scan();
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h03, 8'h10, 8'h05, 8'h30);
    ticks(1, 4'd3); scan();
    // R4: day of week 7 -> 1
    cur_req = "R4";
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h07, 8'h10, 8'h05, 8'h30);
    ticks(1, 4'd4); scan();
    // R5: month lengths
    cur_req = "R5";
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h30, 8'h04, 8'h30);
    ticks(1, 4'd5); scan();
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h30, 8'h03, 8'h30);
    ticks(1, 4'd5); scan();
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h31, 8'h01, 8'h30);
    ticks(1, 4'd6); scan();
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h28, 8'h02, 8'h23);
    ticks(1, 4'd5); scan();
    // R6: leap years
    cur_req = "R6";
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h28, 8'h02, 8'h24);
    ticks(1, 4'd5); scan();
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h29, 8'h02, 8'h24);
    ticks(1, 4'd5); scan();
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h28, 8'h02, 8'h00);
    ticks(1, 4'd5); scan();
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h01, 8'h28, 8'h02, 8'h30);
    ticks(1, 4'd5); scan();
    // R7: year end and century bit
    cur_req = "R7";
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h05, 8'h31, 8'h12, 8'h99);
    ticks(1, 4'd6); scan();
    set_time(8'h23, 8'h59, 8'h59, 8'h99, 8'h05, 8'h31, 8'h92, 8'h99);
    ticks(1, 4'd6); scan();
    // R8: write wins over tick, alarm register readback
    cur_req = "R8";
    set_time(8'h08, 8'h15, 8'h20, 8'h50, 8'h02, 8'h11, 8'h07, 8'h45);
    step(1, 1, 0, 4'd1, 8'h42);
    step(1, 1, 0, 4'd8, 8'h77);
    wr(4'd9, 8'h30); wr(4'd10, 8'h20); wr(4'd11, 8'h10); wr(4'd12, 8'h05); wr(4'd13, 8'h06);
    scan();
    // R9: armed match fires, unarmed and write-only do not
    cur_req = "R9";
    set_time(8'h10, 8'h20, 8'h29, 8'h98, 8'h01, 8'h05, 8'h06, 8'h45);
    ticks(3, 4'd14);
    wr(4'd13, 8'h86);
    set_time(8'h10, 8'h20, 8'h30, 8'h00, 8'h01, 8'h05, 8'h06, 8'h45);
    step(0, 0, 0, 4'd14, 8'h00);
    set_time(8'h10, 8'h20, 8'h29, 8'h98, 8'h01, 8'h05, 8'h06, 8'h45);
    ticks(3, 4'd14);
    // R10: sticky flag, clear on read, set wins
    cur_req = "R10";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 4'd14, 8'h00);
    step(0, 0, 1, 4'd14, 8'h00);
    step(0, 0, 0, 4'd14, 8'h00);
    set_time(8'h10, 8'h20, 8'h29, 8'h99, 8'h01, 8'h05, 8'h06, 8'h45);
    step(1, 0, 1, 4'd14, 8'h00);
    step(0, 0, 0, 4'd14, 8'h00);
    step(0, 0, 1, 4'd14, 8'h00);
    step(0, 0, 0, 4'd14, 8'h00);
    // R11: reserved and spare offsets
    cur_req = "R11";
    wr(4'd0, 8'hFF); wr(4'd15, 8'hFF);
    scan();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule